// File: doc/BRIEF.md
# Aliased General-Purpose Register File

This block holds eight 32-bit general-purpose registers. Each register can be read and written through narrower aliased views. Every register has a 16-bit view of its low half. The first four registers also have two 8-bit views: the lowest byte, and the byte just above it. An execution pipeline drives one write port and two read ports. Each port carries a register index and a size code. A narrow write merges its bits into the stored 32-bit value. A narrow read returns only the selected field, padded with zeros.

Registers 6 and 7 are ordinary storage. By convention they hold the stack pointer and the frame pointer, so the block drives their stored 32-bit contents on two dedicated outputs. A read of the register being written in the same cycle returns the value that the write will leave behind. This also holds when the read and the write use different views of the same register.

Top module: `gpr_alias_file`

## Requirements
- R1: While the asynchronous active-low reset is asserted, all eight registers clear to zero, and all reads and both pointer outputs return zero.
- R2: When the write enable is high, a long write replaces the whole target register at the rising clock edge. When the write enable is low, no register changes.
- R3: In word size, the index selects register 0 to 7 and the field is bits 15:0. A word write keeps bits 31:16 of the target.
- R4: In byte size, index codes 0 to 3 select bits 7:0 of registers 0 to 3, and codes 4 to 7 select bits 15:8 of registers 0 to 3. A byte write keeps all other bits of the target, and it never changes registers 4 to 7.
- R5: A byte read returns the field in bits 7:0 with zeros above. A word read returns the field in bits 15:0 with zeros above.
- R6: The size code is 0 for byte, 1 for word and 2 for long. Code 3 behaves exactly like long.
- R7: When a read port addresses the register being written in the same cycle, it returns the merged post-write value. This applies to partial writes and to different views of the same register.
- R8: The stack-pointer output shows the stored value of register 6, and the frame-pointer output shows the stored value of register 7. Neither output bypasses a pending write.
- R9: The two read ports are independent. Each port can select any register and any view in the same cycle as the other.
- R10: Write data is always taken from the low bits of the data input, whichever byte of the register it lands in. Data bits above the write size are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write index, interpreted according to wr_size |
| wr_size | input | 2 | Write size code (0 byte, 1 word, 2 or 3 long) |
| wr_data | input | 32 | Write data, aligned to bit 0 |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 field, zero-extended |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 field, zero-extended |
| sp_value | output | 32 | Stored contents of register 6 |
| fp_value | output | 32 | Stored contents of register 7 |

## Verification
A read and a write can target the same register in one cycle. The harder case is when the two use different views of that register: for example, a word write to register 0 while the other port reads the upper byte view through code 4. The bench sets up such collisions with both ports active. Before the clock edge it compares each read result with the merged value worked out by hand from the requirements. It also confirms that the pointer outputs still show the old stored value, and that they take the new value only after the edge.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  // Access size codes carried by every port.
  typedef enum logic [1:0] {
    GPR_SZ_BYTE = 2'd0,
    GPR_SZ_WORD = 2'd1,
    GPR_SZ_LONG = 2'd2,
    GPR_SZ_WIDE = 2'd3   // alias of long
  } gpr_size_e;

  localparam int unsigned GPR_LANE_BITS = 8;
  localparam int unsigned GPR_WORD_LANES = 2;

endpackage

// File: rtl/gpr_field_locate.sv
// Maps an (index, size) pair to a physical register, the byte lanes it
// covers and the lane at which the field begins.
module gpr_field_locate
  import gpr_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned BYTE_REGS = 4,
  parameter int unsigned LANES     = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned LANE_W   = $clog2(LANES)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        size,
  output logic [IDX_W-1:0]  reg_sel,
  output logic [LANES-1:0]  lane_en,
  output logic [LANE_W-1:0] lane_off
);

  localparam logic [IDX_W-1:0] BYTE_SPLIT = IDX_W'(BYTE_REGS);
  localparam logic [LANES-1:0] WORD_LANES = LANES'((1 << GPR_WORD_LANES) - 1);

  always_comb begin
    reg_sel  = idx;
    lane_off = '0;
    lane_en  = '1;
    unique case (size)
      GPR_SZ_BYTE: begin
        if (idx >= BYTE_SPLIT) begin
          reg_sel  = idx - BYTE_SPLIT;
          lane_off = LANE_W'(1);
        end
        lane_en = LANES'(1) << lane_off;
      end
      GPR_SZ_WORD: lane_en = WORD_LANES;
      default:     lane_en = '1;
    endcase
  end

endmodule

// File: rtl/gpr_write_merge.sv
// Places bit-0-aligned write data at its lane and keeps untouched lanes.
module gpr_write_merge
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / GPR_LANE_BITS,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_en,
  input  logic [LANE_W-1:0] lane_off,
  output logic [DATA_W-1:0] new_val
);

  logic [DATA_W-1:0] placed;

  always_comb placed = wdata << {lane_off, 3'b000};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      new_val[l*GPR_LANE_BITS +: GPR_LANE_BITS] = lane_en[l]
        ? placed[l*GPR_LANE_BITS +: GPR_LANE_BITS]
        : old_val[l*GPR_LANE_BITS +: GPR_LANE_BITS];
    end
  end

endmodule

// File: rtl/gpr_read_extract.sv
// Selects the addressed lanes and right-aligns them with zero fill.
module gpr_read_extract
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / GPR_LANE_BITS,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] src_val,
  input  logic [LANES-1:0]  lane_en,
  input  logic [LANE_W-1:0] lane_off,
  output logic [DATA_W-1:0] field
);

  logic [DATA_W-1:0] keep_mask;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    always_comb keep_mask[l*GPR_LANE_BITS +: GPR_LANE_BITS] = {GPR_LANE_BITS{lane_en[l]}};
  end

  always_comb field = (src_val & keep_mask) >> {lane_off, 3'b000};

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
  import gpr_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BYTE_REGS = 4,
  parameter int unsigned SP_IDX    = 6,
  parameter int unsigned FP_IDX    = 7,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned LANES    = DATA_W / GPR_LANE_BITS,
  localparam int unsigned LANE_W   = $clog2(LANES),
  localparam int unsigned RD_PORTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_size,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_size,
  output logic [DATA_W-1:0] rd1_data,
  output logic [DATA_W-1:0] sp_value,
  output logic [DATA_W-1:0] fp_value
);

  // ---------------- storage ----------------
  logic [DATA_W-1:0] gpr_q [NUM_REGS];
  logic [NUM_REGS-1:0] gpr_we;

  // ---------------- write path ----------------
  logic [IDX_W-1:0]  wr_reg;
  logic [LANES-1:0]  wr_lanes;
  logic [LANE_W-1:0] wr_off;
  logic [DATA_W-1:0] wr_old;
  logic [DATA_W-1:0] wr_merged;

  gpr_field_locate #(
    .NUM_REGS (NUM_REGS),
    .BYTE_REGS(BYTE_REGS),
    .LANES    (LANES)
  ) u_wr_loc (
    .idx     (wr_idx),
    .size    (wr_size),
    .reg_sel (wr_reg),
    .lane_en (wr_lanes),
    .lane_off(wr_off)
  );

  always_comb wr_old = gpr_q[wr_reg];

  gpr_write_merge #(.DATA_W(DATA_W)) u_wr_merge (
    .old_val (wr_old),
    .wdata   (wr_data),
    .lane_en (wr_lanes),
    .lane_off(wr_off),
    .new_val (wr_merged)
  );

  // One-hot clock enable per register.
  always_comb begin
    gpr_we = '0;
    if (wr_en) gpr_we[wr_reg] = 1'b1;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         gpr_q[r] <= '0;
      else if (gpr_we[r]) gpr_q[r] <= wr_merged;
    end
  end

  // ---------------- read ports ----------------
  logic [IDX_W-1:0]  rd_idx_a  [RD_PORTS];
  logic [1:0]        rd_size_a [RD_PORTS];
  logic [DATA_W-1:0] rd_data_a [RD_PORTS];

  always_comb begin
    rd_idx_a[0]  = rd0_idx;
    rd_size_a[0] = rd0_size;
    rd_idx_a[1]  = rd1_idx;
    rd_size_a[1] = rd1_size;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [IDX_W-1:0]  rsel;
    logic [LANES-1:0]  rlanes;
    logic [LANE_W-1:0] roff;
    logic              hit;
    logic [DATA_W-1:0] src;

    gpr_field_locate #(
      .NUM_REGS (NUM_REGS),
      .BYTE_REGS(BYTE_REGS),
      .LANES    (LANES)
    ) u_rd_loc (
      .idx     (rd_idx_a[p]),
      .size    (rd_size_a[p]),
      .reg_sel (rsel),
      .lane_en (rlanes),
      .lane_off(roff)
    );

    // Write-first bypass on the physical register, so differing views
    // of one register still see the merged value.
    always_comb begin
      hit = wr_en && (wr_reg == rsel);
      src = hit ? wr_merged : gpr_q[rsel];
    end

    gpr_read_extract #(.DATA_W(DATA_W)) u_rd_ext (
      .src_val (src),
      .lane_en (rlanes),
      .lane_off(roff),
      .field   (rd_data_a[p])
    );
  end

  always_comb begin
    rd0_data = rd_data_a[0];
    rd1_data = rd_data_a[1];
    sp_value = gpr_q[SP_IDX];
    fp_value = gpr_q[FP_IDX];
  end

endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk
  import gpr_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BYTE_REGS = 4,
  parameter int unsigned SP_IDX    = 6,
  parameter int unsigned FP_IDX    = 7,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [1:0]        wr_size,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic [1:0]        rd0_size,
  input logic [DATA_W-1:0] rd0_data,
  input logic [IDX_W-1:0]  rd1_idx,
  input logic [1:0]        rd1_size,
  input logic [DATA_W-1:0] rd1_data,
  input logic [DATA_W-1:0] sp_value,
  input logic [DATA_W-1:0] fp_value
);

  localparam logic [IDX_W-1:0] SP_I = IDX_W'(SP_IDX);
  localparam logic [IDX_W-1:0] FP_I = IDX_W'(FP_IDX);

  logic wr_is_long;
  always_comb wr_is_long = (wr_size == GPR_SZ_LONG) || (wr_size == GPR_SZ_WIDE);

  // R2
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(sp_value) && $stable(fp_value)));

  // R2, R6, R8
  a_r6_long_sp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_is_long && wr_idx == SP_I) |=> (sp_value == $past(wr_data)));

  // R3, R10
  a_r3_word_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == GPR_SZ_WORD && wr_idx == FP_I) |=>
      (fp_value[DATA_W-1:16] == $past(fp_value[DATA_W-1:16]) &&
       fp_value[15:0] == $past(wr_data[15:0])));

  // R4
  a_r4_byte_spares_pointers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == GPR_SZ_BYTE) |=> ($stable(sp_value) && $stable(fp_value)));

  // R5
  a_r5_byte_zero_ext0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_size == GPR_SZ_BYTE) |-> (rd0_data[DATA_W-1:8] == '0));
  a_r5_word_zero_ext1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_size == GPR_SZ_WORD) |-> (rd1_data[DATA_W-1:16] == '0));

  // R7
  a_r7_bypass_long0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_is_long && rd0_idx == wr_idx &&
     (rd0_size == GPR_SZ_LONG || rd0_size == GPR_SZ_WIDE)) |-> (rd0_data == wr_data));
  a_r7_bypass_long1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_is_long && rd1_idx == wr_idx &&
     (rd1_size == GPR_SZ_LONG || rd1_size == GPR_SZ_WIDE)) |-> (rd1_data == wr_data));

endmodule

bind gpr_alias_file gpr_alias_file_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .BYTE_REGS(BYTE_REGS),
  .SP_IDX   (SP_IDX),
  .FP_IDX   (FP_IDX)
) u_chk (.*);

// File: tb/tb_gpr_alias_file.sv
module tb_gpr_alias_file;
  import gpr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic [2:0]  rd0_idx, rd1_idx;
  logic [1:0]  rd0_size, rd1_size;
  logic [31:0] rd0_data, rd1_data, sp_value, fp_value;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [8];

  always #5 clk = ~clk;

  gpr_alias_file dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
    .sp_value(sp_value), .fp_value(fp_value)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected field from the requirement text (R3, R4, R5, R6).
  function automatic logic [31:0] exp_read(input logic [2:0] idx, input logic [1:0] sz);
    case (sz)
      2'd0:    exp_read = (idx < 3'd4) ? {24'h0, mdl[idx][7:0]} : {24'h0, mdl[idx - 3'd4][15:8]};
      2'd1:    exp_read = {16'h0, mdl[idx][15:0]};
      default: exp_read = mdl[idx];
    endcase
  endfunction

  function automatic void mdl_write(input logic [2:0] idx, input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0: if (idx < 3'd4) mdl[idx][7:0] = d[7:0];
            else            mdl[idx - 3'd4][15:8] = d[7:0];
      2'd1: mdl[idx][15:0] = d[15:0];
      default: mdl[idx] = d;
    endcase
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_write(input logic [2:0] idx, input logic [1:0] sz, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_data = d;
    @(posedge clk);
    mdl_write(idx, sz, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int port, input logic [2:0] idx, input logic [1:0] sz);
    if (port == 0) begin rd0_idx = idx; rd0_size = sz; end
    else           begin rd1_idx = idx; rd1_size = sz; end
    #1;
    chk(tag, (port == 0) ? rd0_data : rd1_data, exp_read(idx, sz));
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd_chk("R1 reset long read", i % 2, 3'(i), 2'd2);
    chk("R1 reset sp", sp_value, 32'h0);
    chk("R1 reset fp", fp_value, 32'h0);
  endtask

  task automatic t_long_all;
    for (int i = 0; i < 8; i++) do_write(3'(i), 2'd2, 32'h1111_1111 * (i + 1) ^ 32'hA5A5_0F0F);
    for (int i = 0; i < 8; i++) begin
      rd0_idx = 3'(i); rd0_size = 2'd2;
      rd1_idx = 3'(7 - i); rd1_size = 2'd1;
      #1;
      chk("R2 long read port0", rd0_data, exp_read(3'(i), 2'd2));
      chk("R9 word read port1", rd1_data, exp_read(3'(7 - i), 2'd1));
    end
    chk("R8 sp shows reg6", sp_value, mdl[6]);
    chk("R8 fp shows reg7", fp_value, mdl[7]);
  endtask

  task automatic t_wen_low;
    wr_en = 1'b0; wr_idx = 3'd2; wr_size = 2'd2; wr_data = 32'hDEAD_DEAD;
    @(negedge clk);
    rd_chk("R2 idle write ignored", 0, 3'd2, 2'd2);
  endtask

  task automatic t_word;
    do_write(3'd1, 2'd1, 32'hFFFF_BEEF);
    rd_chk("R3 word write keeps upper", 0, 3'd1, 2'd2);
    chk("R10 word ignores high data", rd0_data[31:16], mdl[1][31:16]);
    rd_chk("R5 word read zero-extended", 1, 3'd5, 2'd1);
    do_write(3'd7, 2'd1, 32'h0000_1234);
    chk("R3 word write fp", fp_value, mdl[7]);
  endtask

  task automatic t_byte;
    logic [31:0] sp_before, fp_before;
    do_write(3'd0, 2'd2, 32'h1122_3344);
    do_write(3'd4, 2'd0, 32'hFFFF_FF5A);   // high byte of reg 0
    rd_chk("R4 high byte write merges", 0, 3'd0, 2'd2);
    chk("R4 expected literal", rd0_data, 32'h1122_5A44);
    do_write(3'd3, 2'd0, 32'h0000_00C3);   // low byte of reg 3
    rd_chk("R4 low byte write merges", 1, 3'd3, 2'd2);
    sp_before = sp_value; fp_before = fp_value;
    do_write(3'd6, 2'd0, 32'h0000_0077);   // high byte of reg 2
    chk("R4 byte code 6 spares sp", sp_value, sp_before);
    chk("R4 byte code 7 spares fp", fp_value, fp_before);
    rd_chk("R4 code 6 hits reg2 bits 15:8", 0, 3'd2, 2'd2);
    rd_chk("R5 high byte read zero-extended", 1, 3'd6, 2'd0);
    rd_chk("R5 low byte read zero-extended", 0, 3'd3, 2'd0);
  endtask

  task automatic t_size3;
    do_write(3'd5, 2'd3, 32'hCAFE_F00D);
    rd_chk("R6 size 3 acts as long write", 0, 3'd5, 2'd2);
    rd_chk("R6 size 3 acts as long read", 1, 3'd5, 2'd3);
  endtask

  task automatic t_bypass;
    do_write(3'd0, 2'd2, 32'h1122_3344);
    wr_en = 1'b1; wr_idx = 3'd0; wr_size = 2'd1; wr_data = 32'h0000_ABCD;
    rd0_idx = 3'd0; rd0_size = 2'd2;
    rd1_idx = 3'd4; rd1_size = 2'd0;
    #1;
    chk("R7 bypass partial long view", rd0_data, 32'h1122_ABCD);
    chk("R7 bypass across alias high byte", rd1_data, 32'h0000_00AB);
    @(posedge clk); mdl_write(3'd0, 2'd1, 32'h0000_ABCD);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd6; wr_size = 2'd2; wr_data = 32'h0BAD_F00D;
    rd0_idx = 3'd6; rd0_size = 2'd1;
    #1;
    chk("R7 bypass word view of sp", rd0_data, 32'h0000_F00D);
    chk("R8 sp not bypassed", sp_value, mdl[6]);
    @(posedge clk); mdl_write(3'd6, 2'd2, 32'h0BAD_F00D);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 sp updates after edge", sp_value, 32'h0BAD_F00D);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = 3'd0; wr_size = 2'd0; wr_data = 32'h0;
    rd0_idx = 3'd0; rd0_size = 2'd2; rd1_idx = 3'd0; rd1_size = 2'd2;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_long_all();
    t_wen_low();
    t_word();
    t_byte();
    t_size3();
    t_bypass();
    @(negedge clk);
    finish_run();
  end

endmodule